// File: doc/BRIEF.md
# Tile Write Eliminator

This block sits on the path from a tile buffer to the memory write port. Each finished tile arrives as a stream of 32-bit pixels, one per beat, and the final beat carries a marker and the tile's index. While the tile streams in, the block stores it in a local buffer that holds one tile. It also folds every pixel into a 64-bit cyclic redundancy check.

When the last beat arrives, the block compares the finished signature with the one it kept for the same tile index. If they are equal, the tile is dropped and never reaches memory. A signature collision is accepted as a match, and there is no second check. If the signatures differ, or no signature has been stored for that index since reset, the new signature replaces the old one and the buffered tile is sent out in its original order.

A per-frame counter reports how many tiles have been dropped. A frame-start pulse clears it.

Top module: `twe_tile_elim`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and elim_count is 0.
- R2: After reset every signature entry is invalid, so the first tile seen at an index is always written out in full.
- R3: A tile whose signature equals the stored signature for the same index produces no output beats. It raises elim_count by one in the cycle after its last beat.
- R4: A tile that is written appears on out_data beat for beat in arrival order. out_idx equals the index sampled on its last input beat, and out_last is 1 on the final beat only. The first beat is presented in the cycle after the last input beat.
- R5: A written tile's signature replaces the one stored for its index. The same contents at that index are dropped afterwards, and the older contents are written again.
- R6: The comparison is made only against the entry for the tile's own index. Identical contents at a different index do not cause a drop.
- R7: While a tile is being sent out, in_ready is 0 and input beats are ignored. They do not alter the stored signatures or the buffered tile.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_idx and out_last hold their values.
- R9: frame_start clears elim_count. When it coincides with the last beat of a dropped tile, elim_count becomes 1.
- R10: The signature is the CRC-64 with polynomial 0x42F0E1EBA9EA3693. It is seeded with all ones at each tile's first beat, takes each 32-bit pixel most significant bit first, and has no final inversion. A single flipped bit in a tile therefore makes it differ and forces a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; clears the drop counter |
| in_valid | input | 1 | Input pixel beat valid |
| in_ready | output | 1 | Block accepts input beats |
| in_data | input | 32 | Pixel data |
| in_idx | input | 4 | Tile index, sampled on the last beat |
| in_last | input | 1 | Marks the final beat of a tile |
| out_valid | output | 1 | Output write beat valid |
| out_ready | input | 1 | Memory path accepts the beat |
| out_data | output | 32 | Pixel data being written |
| out_idx | output | 4 | Index of the tile being written |
| out_last | output | 1 | Final beat of the written tile |
| elim_count | output | 5 | Tiles dropped since the last frame start |

## Verification
The frame-start clear and a signature match can land in the same clock edge. In that case the counter must restart from the drop rather than from zero, so it reads 1. The bench provokes this by raising frame_start on the last beat of a tile whose contents repeat the stored tile. It then reads elim_count in the following cycle and expects 1, where a design that lets the clear win would show 0. The second overlap is input arriving while a tile drains under back-pressure. It is judged by showing that the same tile is still dropped on its next pass.

// File: rtl/twe_pkg.sv
package twe_pkg;
   localparam logic [63:0] CRC64_ECMA_POLY = 64'h42F0E1EBA9EA3693;

   typedef enum logic {
      ST_FILL = 1'b0,
      ST_SEND = 1'b1
   } twe_state_e;
endpackage

// File: rtl/twe_crc_step.sv
module twe_crc_step #(
   parameter int          CRC_W  = 64,
   parameter int          DATA_W = 32,
   parameter logic [CRC_W-1:0] POLY = 64'h42F0E1EBA9EA3693
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_out
);
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("twe_crc_step: polynomial must have its x^0 term set");
   end

   // Bit-serial division unrolled over one data word, MSB first.
   always_comb begin
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = crc_in;
      for (int b = DATA_W - 1; b >= 0; b--) begin
         fb  = acc[CRC_W-1] ^ data[b];
         acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      crc_out = acc;
   end
endmodule

// File: rtl/twe_tile_fifo.sv
module twe_tile_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic [CW-1:0]     fill
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("twe_tile_fifo: DEPTH must be at least 1");
   end

   logic [DATA_W-1:0] mem [0:(1<<AW)-1];
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     rd_q;

   always_ff @(posedge clk) begin
      if (wr_en && !flush) mem[cnt_q[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rd_q  <= '0;
      end else if (flush) begin
         cnt_q <= '0;
         rd_q  <= '0;
      end else begin
         if (wr_en) cnt_q <= cnt_q + CW'(1);
         if (rd_en) rd_q  <= rd_q + CW'(1);
      end
   end

   assign rd_data = mem[rd_q[AW-1:0]];
   assign rd_last = (cnt_q != '0) && (rd_q == cnt_q - CW'(1));
   assign fill    = cnt_q;

   // A tile must fit in the buffer.
   a_r4_fifo_room: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |-> (cnt_q < CW'(DEPTH)));
   // Reads never run past the stored beats.
   a_r4_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_q < cnt_q));
endmodule

// File: rtl/twe_sig_table.sv
module twe_sig_table #(
   parameter int CRC_W   = 64,
   parameter int ENTRIES = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CRC_W-1:0] rd_sig,
   output logic             rd_hit_ok,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CRC_W-1:0] wr_sig
);
   if (ENTRIES < 1) begin : g_bad_entries
      $error("twe_sig_table: ENTRIES must be at least 1");
   end

   logic [CRC_W-1:0] sig_q [ENTRIES];
   logic             vld_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            sig_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            vld_q[g] <= 1'b1;
            sig_q[g] <= wr_sig;
         end
      end
   end

   always_comb begin
      rd_sig    = '0;
      rd_hit_ok = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (rd_idx == IDX_W'(e)) begin
            rd_sig    = sig_q[e];
            rd_hit_ok = vld_q[e];
         end
      end
   end

   // A stored signature is readable, and valid, on the next cycle.
   a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (rd_idx == wr_idx)) |=> ((rd_idx != $past(wr_idx)) ||
                                        (rd_hit_ok && rd_sig == $past(wr_sig))));
endmodule

// File: rtl/twe_tile_elim.sv
module twe_tile_elim #(
   parameter int  PIX_W     = 32,
   parameter int  TILE_PIX  = 16,
   parameter int  MAX_TILES = 16,
   parameter int  CRC_W     = 64,
   parameter bit  CNT_SAT   = 1'b1,
   localparam int IDX_W     = (MAX_TILES > 1) ? $clog2(MAX_TILES) : 1,
   localparam int CNT_W     = $clog2(MAX_TILES + 1),
   localparam int FILL_W    = $clog2(TILE_PIX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_data,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PIX_W-1:0]  out_data,
   output logic [IDX_W-1:0]  out_idx,
   output logic              out_last,
   output logic [CNT_W-1:0]  elim_count
);
   import twe_pkg::*;

   if (CRC_W != 64) begin : g_bad_crc
      $error("twe_tile_elim: only a 64-bit signature is supported");
   end
   if (TILE_PIX < 1 || MAX_TILES < 1) begin : g_bad_size
      $error("twe_tile_elim: TILE_PIX and MAX_TILES must be positive");
   end

   twe_state_e       state_q;
   logic             first_q;
   logic [CRC_W-1:0] crc_q, crc_base, crc_next;
   logic [CRC_W-1:0] stored_sig;
   logic             stored_ok;
   logic             accept, tile_end, hit, miss, pop, rd_last;
   logic [FILL_W-1:0] fill;

   assign in_ready  = (state_q == ST_FILL);
   assign out_valid = (state_q == ST_SEND);
   assign accept    = in_valid && in_ready;
   assign tile_end  = accept && in_last;
   assign pop       = out_valid && out_ready;

   // Signature datapath
   assign crc_base = first_q ? {CRC_W{1'b1}} : crc_q;

   twe_crc_step #(.CRC_W(CRC_W), .DATA_W(PIX_W), .POLY(CRC64_ECMA_POLY)) u_crc (
      .crc_in (crc_base),
      .data   (in_data),
      .crc_out(crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= '1;
         first_q <= 1'b1;
      end else if (accept) begin
         crc_q   <= crc_next;
         first_q <= in_last;
      end
   end

   // Signature table and decision
   twe_sig_table #(.CRC_W(CRC_W), .ENTRIES(MAX_TILES)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (in_idx),
      .rd_sig   (stored_sig),
      .rd_hit_ok(stored_ok),
      .wr_en    (miss),
      .wr_idx   (in_idx),
      .wr_sig   (crc_next)
   );

   assign hit  = tile_end && stored_ok && (stored_sig == crc_next);
   assign miss = tile_end && !hit;

   // One-tile staging buffer
   twe_tile_fifo #(.DATA_W(PIX_W), .DEPTH(TILE_PIX)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (hit || (pop && rd_last)),
      .wr_en  (accept),
      .wr_data(in_data),
      .rd_en  (pop),
      .rd_data(out_data),
      .rd_last(rd_last),
      .fill   (fill)
   );

   assign out_last = rd_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FILL;
         out_idx <= '0;
      end else begin
         case (state_q)
            ST_FILL: if (miss) begin
               state_q <= ST_SEND;
               out_idx <= in_idx;
            end
            ST_SEND: if (pop && rd_last) state_q <= ST_FILL;
            default: state_q <= ST_FILL;
         endcase
      end
   end

   // Drop counter, cleared per frame
   logic [CNT_W-1:0] cnt_inc;
   if (CNT_SAT) begin : g_cnt_sat
      assign cnt_inc = (elim_count == {CNT_W{1'b1}}) ? elim_count : elim_count + CNT_W'(1);
   end else begin : g_cnt_wrap
      assign cnt_inc = elim_count + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                elim_count <= '0;
      else if (frame_start && hit) elim_count <= CNT_W'(1);
      else if (frame_start)      elim_count <= '0;
      else if (hit)              elim_count <= cnt_inc;
   end

   // ---------------- assertions ----------------
   a_r7_no_input_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
   a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_idx) && $stable(out_last)));
   a_r3_drop_sends_nothing: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (!out_valid && fill == '0));
   a_r4_write_starts_next: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> (out_valid && out_idx == $past(in_idx)));
   a_r9_clear_and_count: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && hit) |=> (elim_count == CNT_W'(1)));
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !hit) |=> (elim_count == '0));
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !hit) |=> $stable(elim_count));
   a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      tile_end |-> (32'(in_idx) < MAX_TILES));
endmodule

// File: tb/sim_twe_tile_elim.sv
module sim_twe_tile_elim;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic [3:0]  in_idx = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;
   logic [3:0]  out_idx;
   logic        out_last;
   logic [4:0]  elim_count;

   int n_run = 0;
   int n_fail = 0;
   int exp_cnt = 0;

   always #4 clk = ~clk;

   twe_tile_elim u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_idx(in_idx), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_idx(out_idx), .out_last(out_last), .elim_count(elim_count)
   );

   // Fields: [42] frame_start, [41:38] index, [37:33] length,
   //         [32:1] first pixel, [0] expect written
   localparam int NV = 11;
   localparam logic [42:0] VEC [NV] = '{
      {1'b1, 4'd0,  5'd4,  32'hCAFE0000, 1'b1},  // R2 first at index 0
      {1'b0, 4'd1,  5'd4,  32'hCAFE0000, 1'b1},  // R6 same pixels, other index
      {1'b1, 4'd0,  5'd4,  32'hCAFE0000, 1'b0},  // R3 repeat dropped
      {1'b0, 4'd1,  5'd4,  32'h12345678, 1'b1},  // R4 changed tile written
      {1'b1, 4'd1,  5'd4,  32'h12345678, 1'b0},  // R5 new signature kept
      {1'b0, 4'd0,  5'd4,  32'h0F0F0F0F, 1'b1},  // R4
      {1'b1, 4'd0,  5'd4,  32'hCAFE0000, 1'b1},  // R5 old content rewritten
      {1'b0, 4'd15, 5'd16, 32'hDEAD0001, 1'b1},  // R4 full tile, top index
      {1'b1, 4'd15, 5'd16, 32'hDEAD0001, 1'b0},  // R3
      {1'b0, 4'd2,  5'd1,  32'h00000000, 1'b1},  // R2 one-beat tile
      {1'b0, 4'd2,  5'd1,  32'h00000000, 1'b0}   // R3 within one frame
   };

   function automatic logic [31:0] pix(input logic [31:0] base, input int k);
      return base + 32'(k) * 32'h00010001;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] idx, input int len, input logic [31:0] base,
                       input bit fs_first, input bit fs_last, input bit drop);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         in_valid    = 1'b1;
         in_data     = pix(base, k);
         in_idx      = idx;
         in_last     = (k == len - 1);
         frame_start = (fs_first && k == 0) || (fs_last && k == len - 1);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; frame_start = 1'b0;
      if (fs_first || fs_last) exp_cnt = 0;
      if (drop) exp_cnt++;
   endtask

   // Called at the negedge after the last input beat, out_ready high.
   task automatic recv(input string req, input logic [3:0] idx, input int len,
                       input logic [31:0] base);
      for (int k = 0; k < len; k++) begin
         check({req, " valid"}, 64'(out_valid), 64'd1);
         check({req, " data"},  64'(out_data),  64'(pix(base, k)));
         check({req, " idx"},   64'(out_idx),   64'(idx));
         check({req, " last"},  64'(out_last),  64'(k == len - 1));
         @(negedge clk);
      end
      check({req, " done"}, 64'(out_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 out_valid", 64'(out_valid), 64'd0);
      check("R1 in_ready",  64'(in_ready),  64'd1);
      check("R1 count",     64'(elim_count), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         send(VEC[v][41:38], int'(VEC[v][37:33]), VEC[v][32:1], VEC[v][42], 1'b0, !VEC[v][0]);
         if (VEC[v][0]) recv("R4 vector write", VEC[v][41:38], int'(VEC[v][37:33]), VEC[v][32:1]);
         else check("R3 vector drop no output", 64'(out_valid), 64'd0);
         check("R3 vector count", 64'(elim_count), 64'(exp_cnt));
      end

      // R10: one flipped bit at index 2 (stored pixel was zero)
      send(4'd2, 1, 32'h00000001, 1'b0, 1'b0, 1'b0);
      recv("R10 single bit change", 4'd2, 1, 32'h00000001);
      check("R10 count", 64'(elim_count), 64'(exp_cnt));

      // R7/R8: back-pressure during a send while input is offered
      send(4'd3, 3, 32'h5A5A0003, 1'b0, 1'b0, 1'b0);
      out_ready = 1'b0;
      in_valid = 1'b1; in_last = 1'b1; in_idx = 4'd3; in_data = 32'hFFFF_FFFF;
      for (int c = 0; c < 3; c++) begin
         check("R8 hold valid", 64'(out_valid), 64'd1);
         check("R8 hold data",  64'(out_data),  64'(pix(32'h5A5A0003, 0)));
         check("R8 hold last",  64'(out_last),  64'd0);
         check("R7 in_ready low", 64'(in_ready), 64'd0);
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0;
      out_ready = 1'b1;
      recv("R7 tile intact", 4'd3, 3, 32'h5A5A0003);
      send(4'd3, 3, 32'h5A5A0003, 1'b0, 1'b0, 1'b1);
      check("R7 ignored beats left signature", 64'(out_valid), 64'd0);
      check("R7 count", 64'(elim_count), 64'(exp_cnt));

      // R9: lone frame_start clears
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      exp_cnt = 0;
      check("R9 clear", 64'(elim_count), 64'd0);

      // R9: frame_start on the last beat of a dropped tile
      send(4'd1, 4, 32'h12345678, 1'b0, 1'b0, 1'b1);
      check("R9 pre count", 64'(elim_count), 64'd1);
      send(4'd3, 3, 32'h5A5A0003, 1'b0, 1'b1, 1'b1);
      check("R9 coincident clear and drop", 64'(elim_count), 64'(exp_cnt));
      check("R9 expect one", 64'(exp_cnt), 64'd1);
      check("R9 no output", 64'(out_valid), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule